// File: doc/BRIEF.md
# Armed Multi-Lane Byte Snapshot Engine

This block takes a one-shot debug snapshot of several receive lanes at once. Each lane delivers a byte stream with a valid qualifier, a marker on the first byte of each multiframe and a flag that says its stream has been released downstream. Software raises an arm control; every lane then waits for its own trigger, lets a programmable number of 8-byte groups pass, and records the next 16 valid bytes. When a lane has all 16 bytes it raises its own done flag.

Two trigger rules exist. In release mode a lane fires as soon as the engine is armed, system enable is high and that lane's stream is released, so arming before enable makes each lane wait for its own release. In boundary mode each lane fires on its first multiframe marker after arming, which lets lanes fire at different points. A capture happens once per rising edge of arm; dropping arm, dropping system enable or pulsing the soft reset wipes the done flags.

A page select picks one lane; the read port shows that lane's done flag and its 16 bytes as one 128-bit word.

Top module: `lane_snap_capture`

## Requirements
- R1: Arming happens on a 0-to-1 change of `arm`; each arming yields at most one capture per lane, holding `arm` high never starts a second one, and a new 0-to-1 change starts a fresh capture.
- R2: With `trig_mode` = 0 a lane fires in the first cycle in which it is armed and pending, `sys_en` is 1 and its `lane_rel` bit is 1; if arming happened while `sys_en` was 0 the pending arming is kept and each lane fires only once enable and its own release are both present. The valid byte (if any) in the firing cycle is the first byte counted.
- R3: With `trig_mode` = 1 a lane fires on its first beat after arming that has both `lane_vld` and `lane_mfs` set, while `sys_en` is 1; lanes fire independently, and that marked byte is the first byte counted.
- R4: After firing, a lane discards `skip_groups`×8 valid bytes before capturing; cycles with `lane_vld` = 0 are not counted.
- R5: A lane captures 16 consecutive valid bytes; the k-th captured byte (k = 0 first) sits in `rd_data[8k+7:8k]`, and the lane's done flag rises in the cycle after the 16th byte.
- R6: Done flags and captures in progress are cleared whenever `arm` = 0, `sys_en` = 0 or `soft_rst` = 1; `arm` = 0 or `soft_rst` = 1 also cancels a pending arming, while `sys_en` = 0 leaves it pending.
- R7: `trig_mode` codes 2 through 15 never fire any lane.
- R8: For `page_sel` below the lane count, `rd_done` is that lane's done flag and `rd_data` its capture, with `rd_data` zero while the flag is low; a `page_sel` at or above the lane count reads `rd_done` = 0 and `rd_data` = 0.
- R9: After `rst` no lane is done and no arming is pending, even if `arm` is already high it is seen as a fresh 0-to-1 change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous clear of arming and captures |
| sys_en | input | 1 | System enable |
| arm | input | 1 | Arm control, acts on its rising edge |
| trig_mode | input | 4 | 0 release trigger, 1 multiframe trigger, others inert |
| skip_groups | input | OFS_W (16) | Delay after trigger in units of 8 valid bytes |
| page_sel | input | PAGE_W (3) | Lane select for the read port |
| lane_data | input | LANES*8 (32) | Lane bytes, lane n in bits 8n+7:8n |
| lane_vld | input | LANES (4) | Byte valid per lane |
| lane_mfs | input | LANES (4) | Multiframe start marker per lane |
| lane_rel | input | LANES (4) | Stream released flag per lane |
| rd_done | output | 1 | Done flag of the selected lane |
| rd_data | output | 128 | Captured bytes of the selected lane |

## Verification
The hardest situation to reach is an arming that must survive a period with system enable low and then release lanes one by one at staggered cycles, combined with gaps in the valid pattern that stretch both the skip window and the capture window. The stimulus arms with enable low, raises enable later and releases each lane on its own schedule, while a periodic valid pattern with per-lane phase forces every lane to count through gaps at different points. Multiframe markers are placed at per-lane phases so that boundary mode fires each lane on a different beat, and a held-high arm after completion checks that nothing recaptures.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int SNAP_BYTES = 16;
    localparam int SNAP_BITS  = SNAP_BYTES * 8;
    localparam int GRAB_W     = $clog2(SNAP_BYTES);

    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_SKIP = 2'd1,
        LN_GRAB = 2'd2,
        LN_DONE = 2'd3
    } lane_st_e;

    localparam logic [3:0] TRG_RELEASE  = 4'd0;
    localparam logic [3:0] TRG_BOUNDARY = 4'd1;

    typedef struct packed {
        logic [7:0] data;
        logic       vld;
        logic       mfs;
        logic       rel;
    } lane_beat_t;

    // Trigger condition of one lane for one beat; unknown modes never fire.
    function automatic logic trig_hit(input logic [3:0] mode,
                                      input logic       en,
                                      input lane_beat_t b);
        case (mode)
            TRG_RELEASE:  return en & b.rel;
            TRG_BOUNDARY: return en & b.vld & b.mfs;
            default:      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lsc_arm_ctrl.sv
module lsc_arm_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic sys_en,
    input  logic soft_rst,
    output logic arm_rise,
    output logic pend_clr,
    output logic lane_clr
);

    logic arm_q;

    always_ff @(posedge clk) begin
        if (rst) arm_q <= 1'b0;
        else     arm_q <= arm;
    end

    assign arm_rise = arm & ~arm_q & ~soft_rst;
    assign pend_clr = soft_rst | ~arm;
    assign lane_clr = soft_rst | ~arm | ~sys_en;

    // R1: an arming edge can never repeat on the next cycle
    a_r1_rise_single: assert property (@(posedge clk) disable iff (rst)
        arm_rise |=> !arm_rise);

endmodule

// File: rtl/lsc_lane.sv
module lsc_lane
    import lsc_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 arm_rise,
    input  logic                 pend_clr,
    input  logic                 lane_clr,
    input  logic                 sys_en,
    input  logic [3:0]           mode,
    input  logic [OFS_W-1:0]     offset,
    input  lane_beat_t           beat,
    output logic                 done,
    output logic [SNAP_BITS-1:0] snap
);

    localparam int SKIP_W = OFS_W + 3;

    lane_st_e          st;
    logic              pend;
    logic [SKIP_W-1:0] skip_left;
    logic [GRAB_W-1:0] cnt;
    logic              start;
    logic              ofs_zero;
    logic [SKIP_W-1:0] skip_load;
    logic              cap_now;
    logic [GRAB_W-1:0] cap_idx;

    assign ofs_zero  = (offset == '0);
    assign skip_load = {offset, 3'b000};
    assign start     = pend & (st == LN_IDLE) & ~lane_clr & trig_hit(mode, sys_en, beat);

    // Pending arming per lane
    always_ff @(posedge clk) begin
        if (rst)           pend <= 1'b0;
        else if (pend_clr) pend <= 1'b0;
        else if (arm_rise) pend <= 1'b1;
        else if (start)    pend <= 1'b0;
    end

    // Lane sequencer
    always_ff @(posedge clk) begin
        if (rst || lane_clr) begin
            st        <= LN_IDLE;
            cnt       <= '0;
            skip_left <= '0;
        end else begin
            case (st)
                LN_IDLE: begin
                    if (start) begin
                        if (ofs_zero) begin
                            st  <= LN_GRAB;
                            cnt <= beat.vld ? GRAB_W'(1) : '0;
                        end else begin
                            st        <= LN_SKIP;
                            skip_left <= beat.vld ? skip_load - 1'b1 : skip_load;
                        end
                    end
                end
                LN_SKIP: begin
                    if (beat.vld) begin
                        skip_left <= skip_left - 1'b1;
                        if (skip_left == SKIP_W'(1)) st <= LN_GRAB;
                    end
                end
                LN_GRAB: begin
                    if (beat.vld) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == GRAB_W'(SNAP_BYTES - 1)) st <= LN_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    // Capture store: byte k of the snapshot at bits 8k+7:8k
    assign cap_now = ~lane_clr & beat.vld &
                     ((st == LN_GRAB) | (start & ofs_zero));
    assign cap_idx = (st == LN_GRAB) ? cnt : '0;

    always_ff @(posedge clk) begin
        if (cap_now) snap[{cap_idx, 3'b000} +: 8] <= beat.data;
    end

    assign done = (st == LN_DONE);

    // R1: firing consumes the pending arming
    a_r1_start_consumes: assert property (@(posedge clk) disable iff (rst)
        start |=> !pend);

    // R6: any clear source drops the done flag on the next cycle
    a_r6_clear_drops_done: assert property (@(posedge clk) disable iff (rst)
        lane_clr |=> !done);

    // R7: inert mode codes never fire a lane
    a_r7_reserved_idle: assert property (@(posedge clk) disable iff (rst)
        (mode > TRG_BOUNDARY) |-> !start);

    // R4: beats without valid do not advance the skip window
    a_r4_skip_hold: assert property (@(posedge clk) disable iff (rst)
        (st == LN_SKIP && !beat.vld && !lane_clr) |=> (st == LN_SKIP && $stable(skip_left)));

    // R5: every valid beat in the capture window stores exactly one byte
    a_r5_grab_step: assert property (@(posedge clk) disable iff (rst)
        (st == LN_GRAB && beat.vld && !lane_clr) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/lsc_page_mux.sv
module lsc_page_mux
    import lsc_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PAGE_W = 3
) (
    input  logic [PAGE_W-1:0]          page_sel,
    input  logic [LANES-1:0]           done_vec,
    input  logic [LANES*SNAP_BITS-1:0] snap_flat,
    output logic                       rd_done,
    output logic [SNAP_BITS-1:0]       rd_data
);

    always_comb begin
        rd_done = 1'b0;
        rd_data = '0;
        for (int i = 0; i < LANES; i++) begin
            if (page_sel == PAGE_W'(i) && done_vec[i]) begin
                rd_done = 1'b1;
                rd_data = snap_flat[i*SNAP_BITS +: SNAP_BITS];
            end
        end
    end

endmodule

// File: rtl/lane_snap_capture.sv
module lane_snap_capture
    import lsc_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int OFS_W  = 16,
    parameter int PAGE_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 soft_rst,
    input  logic                 sys_en,
    input  logic                 arm,
    input  logic [3:0]           trig_mode,
    input  logic [OFS_W-1:0]     skip_groups,
    input  logic [PAGE_W-1:0]    page_sel,
    input  logic [LANES*8-1:0]   lane_data,
    input  logic [LANES-1:0]     lane_vld,
    input  logic [LANES-1:0]     lane_mfs,
    input  logic [LANES-1:0]     lane_rel,
    output logic                 rd_done,
    output logic [SNAP_BITS-1:0] rd_data
);

    logic                       arm_rise;
    logic                       pend_clr;
    logic                       lane_clr;
    logic [LANES-1:0]           done_vec;
    logic [LANES*SNAP_BITS-1:0] snap_flat;

    lsc_arm_ctrl u_arm (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .sys_en   (sys_en),
        .soft_rst (soft_rst),
        .arm_rise (arm_rise),
        .pend_clr (pend_clr),
        .lane_clr (lane_clr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_beat_t beat;
        assign beat.data = lane_data[g*8 +: 8];
        assign beat.vld  = lane_vld[g];
        assign beat.mfs  = lane_mfs[g];
        assign beat.rel  = lane_rel[g];

        lsc_lane #(.OFS_W(OFS_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .arm_rise (arm_rise),
            .pend_clr (pend_clr),
            .lane_clr (lane_clr),
            .sys_en   (sys_en),
            .mode     (trig_mode),
            .offset   (skip_groups),
            .beat     (beat),
            .done     (done_vec[g]),
            .snap     (snap_flat[g*SNAP_BITS +: SNAP_BITS])
        );
    end

    lsc_page_mux #(.LANES(LANES), .PAGE_W(PAGE_W)) u_mux (
        .page_sel  (page_sel),
        .done_vec  (done_vec),
        .snap_flat (snap_flat),
        .rd_done   (rd_done),
        .rd_data   (rd_data)
    );

    // R8: a page beyond the lane count reads as all zero
    a_r8_page_oob: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, page_sel} >= (PAGE_W+1)'(LANES)) |-> (!rd_done && rd_data == '0));

    // R8: read data is zero whenever the selected done flag is low
    a_r8_data_gated: assert property (@(posedge clk) disable iff (rst)
        !rd_done |-> (rd_data == '0));

    // R9: nothing reads as done right after reset
    a_r9_reset_clean: assert property (@(posedge clk)
        $past(rst) |-> !rd_done);

endmodule

// File: tb/lane_snap_capture_tb.sv
`timescale 1ns/100ps
module lane_snap_capture_tb;

    localparam int L  = 4;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          soft_rst = 1'b0;
    logic          sys_en = 1'b0;
    logic          arm = 1'b0;
    logic [3:0]    trig_mode = 4'd0;
    logic [15:0]   skip_groups = 16'd0;
    logic [PW-1:0] page_sel = '0;
    logic [L*8-1:0] lane_data = '0;
    logic [L-1:0]  lane_vld = '0;
    logic [L-1:0]  lane_mfs = '0;
    logic [L-1:0]  lane_rel = '0;
    logic          rd_done;
    logic [127:0]  rd_data;

    lane_snap_capture #(.LANES(L), .OFS_W(16), .PAGE_W(PW)) u_dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .sys_en(sys_en), .arm(arm),
        .trig_mode(trig_mode), .skip_groups(skip_groups), .page_sel(page_sel),
        .lane_data(lane_data), .lane_vld(lane_vld), .lane_mfs(lane_mfs),
        .lane_rel(lane_rel), .rd_done(rd_done), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Stimulus controls
    int cyc = 0;
    int bcnt [L];
    bit gap_en = 1'b0;
    bit mfs_en = 1'b0;
    bit rel_all = 1'b0;
    bit rel_stag = 1'b0;
    int rel_t0 = 0;

    initial for (int l = 0; l < L; l++) bcnt[l] = 0;

    always @(negedge clk) begin
        cyc++;
        for (int l = 0; l < L; l++) begin
            logic v;
            v = gap_en ? (((cyc + l) % 3) != 0) : 1'b1;
            lane_vld[l] = v;
            lane_data[l*8 +: 8] = 8'((bcnt[l] * 7 + l * 50 + 3) & 255);
            lane_mfs[l] = mfs_en && v && (((bcnt[l] + l * 5) % 20) == 0);
            lane_rel[l] = rel_all || (rel_stag && (cyc >= rel_t0 + l * 15));
            if (v) bcnt[l]++;
        end
    end

    // Reference model built from the requirements
    bit         m_armq;
    bit         m_pend [L];
    int         m_st   [L];
    int         m_skip [L];
    int         m_cnt  [L];
    logic [7:0] m_buf  [L][16];

    always @(posedge clk) begin
        if (rst) begin
            m_armq = 1'b0;
            for (int l = 0; l < L; l++) begin
                m_pend[l] = 1'b0; m_st[l] = 0; m_cnt[l] = 0; m_skip[l] = 0;
            end
        end else begin
            bit rise;
            bit clr;
            rise = arm && !m_armq;
            clr  = soft_rst || !sys_en || !arm;
            for (int l = 0; l < L; l++) begin
                bit hit;
                bit strt;
                bit v;
                logic [7:0] d;
                v = lane_vld[l];
                d = lane_data[l*8 +: 8];
                hit = (trig_mode == 4'd0 && sys_en && lane_rel[l]) ||
                      (trig_mode == 4'd1 && sys_en && v && lane_mfs[l]);
                strt = 1'b0;
                if (clr) begin
                    m_st[l] = 0; m_cnt[l] = 0;
                end else begin
                    case (m_st[l])
                        0: if (m_pend[l] && hit) begin
                            strt = 1'b1;
                            if (skip_groups == 0) begin
                                m_st[l] = 2;
                                if (v) begin m_buf[l][0] = d; m_cnt[l] = 1; end
                            end else begin
                                m_skip[l] = int'(skip_groups) * 8;
                                if (v) m_skip[l]--;
                                m_st[l] = 1;
                            end
                        end
                        1: if (v) begin
                            m_skip[l]--;
                            if (m_skip[l] == 0) m_st[l] = 2;
                        end
                        2: if (v) begin
                            m_buf[l][m_cnt[l]] = d;
                            m_cnt[l]++;
                            if (m_cnt[l] == 16) m_st[l] = 3;
                        end
                        default: ;
                    endcase
                end
                if (soft_rst || !arm) m_pend[l] = 1'b0;
                else if (rise)        m_pend[l] = 1'b1;
                else if (strt)        m_pend[l] = 1'b0;
            end
            m_armq = arm;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Checks every page, including pages past the lane count (R8)
    task automatic check_all(input string tag);
        for (int p = 0; p < (1 << PW); p++) begin
            logic         e_done;
            logic [127:0] e_data;
            page_sel = PW'(p);
            #0.2;
            e_done = (p < L) && (m_st[p % L] == 3);
            e_data = '0;
            if (e_done) for (int k = 0; k < 16; k++) e_data[k*8 +: 8] = m_buf[p][k];
            n_tests++;
            if (rd_done !== e_done) begin
                n_fail++;
                $display("FAIL %s page %0d done: actual %0b expected %0b", tag, p, rd_done, e_done);
            end
            n_tests++;
            if (rd_data !== e_data) begin
                n_fail++;
                $display("FAIL %s page %0d data: actual %h expected %h", tag, p, rd_data, e_data);
            end
        end
    endtask

    task automatic count_done(input int exp, input string tag);
        int c = 0;
        for (int p = 0; p < L; p++) begin
            page_sel = PW'(p);
            #0.2;
            if (rd_done) c++;
        end
        n_tests++;
        if (c != exp) begin
            n_fail++;
            $display("FAIL %s done lanes: actual %0d expected %0d", tag, c, exp);
        end
    endtask

    initial begin
        step(4);
        rst = 1'b0;
        step(2);
        check_all("R9 reset state");

        // R2 R4 R5: release trigger, offset and gap sweep
        for (int g = 0; g < 2; g++) begin
            for (int oi = 0; oi < 4; oi++) begin
                int ofs;
                ofs = (oi == 3) ? 5 : oi;
                gap_en = (g == 1);
                rel_all = 1'b1; sys_en = 1'b1; trig_mode = 4'd0;
                skip_groups = 16'(ofs);
                arm = 1'b1;
                step(150);
                check_all($sformatf("R2 R4 R5 ofs %0d gap %0d", ofs, g));
                count_done(L, "R5 all lanes done");
                arm = 1'b0;
                step(2);
                check_all("R6 arm low clears");
            end
        end

        // R2: armed before enable, staggered release
        gap_en = 1'b1; rel_all = 1'b0; sys_en = 1'b0; skip_groups = 16'd1;
        arm = 1'b1;
        step(20);
        check_all("R2 pending with enable low");
        sys_en = 1'b1;
        step(10);
        rel_t0 = cyc; rel_stag = 1'b1;
        step(30);
        check_all("R2 staggered release midway");
        step(150);
        check_all("R2 staggered release");
        count_done(L, "R2 all lanes after release");
        arm = 1'b0; rel_stag = 1'b0; rel_all = 1'b1;
        step(2);

        // R3: boundary trigger, then R1 hold and re-arm
        for (int oi = 0; oi < 2; oi++) begin
            mfs_en = 1'b1; trig_mode = 4'd1; skip_groups = 16'(oi * 2);
            arm = 1'b1;
            step(200);
            check_all($sformatf("R3 boundary ofs %0d", oi * 2));
            count_done(L, "R3 all lanes done");
            step(120);
            check_all("R1 held arm no recapture");
            arm = 1'b0;
            step(1);
            arm = 1'b1;
            step(200);
            check_all("R1 re-arm fresh capture");
            arm = 1'b0;
            step(2);
        end
        mfs_en = 1'b0;

        // R7: inert mode codes
        for (int mi = 0; mi < 3; mi++) begin
            trig_mode = (mi == 0) ? 4'd2 : ((mi == 1) ? 4'd3 : 4'd15);
            skip_groups = 16'd0;
            arm = 1'b1;
            step(80);
            check_all($sformatf("R7 mode %0d", trig_mode));
            count_done(0, "R7 no lane done");
            arm = 1'b0;
            step(2);
        end

        // R6: enable drop and soft reset
        trig_mode = 4'd0; gap_en = 1'b0;
        arm = 1'b1;
        step(40);
        count_done(L, "R6 setup done");
        sys_en = 1'b0;
        step(1);
        check_all("R6 enable low clears");
        sys_en = 1'b1;
        step(60);
        check_all("R6 R1 no recapture after enable returns");
        arm = 1'b0;
        step(1);
        arm = 1'b1;
        step(40);
        soft_rst = 1'b1;
        step(1);
        soft_rst = 1'b0;
        check_all("R6 soft reset clears");
        step(60);
        check_all("R6 soft reset cancels arming");
        count_done(0, "R6 soft reset no capture");
        arm = 1'b0;
        step(2);

        // R9: reset with arm high is a fresh arming
        arm = 1'b1;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
        check_all("R9 after reset");
        step(60);
        check_all("R9 arm high through reset captures");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1600000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule